// File: doc/BRIEF.md
# Double-Buffered Auto-Reload Timer

This block is an up-counting timer/counter with a software-written reload value. The count advances by one on each enabled step. A step is either a tick from one of two external prescaler outputs or a rising edge on an external event pin. When the count passes the top of its range, the block sets a sticky overflow flag and either restarts from the reload value or wraps to zero. Software can gate that flag onto an interrupt line.

The reload value is written into a holding register. It moves into the active register only at an overflow, so a rewrite in mid-period never shortens or stretches the period in progress. In PWM mode the period is 256, 64, 32 or 16 steps, selected by two mode bits. The count restarts from zero at each period end, and the active reload value, masked to the period's width, sets the duty cycle of the PWM output.

Software reaches the block through a write port with four registers, selected by `wr_sel`: 0 = control, 1 = reload holding register, 2 = direct count load, 3 = flag clear. The control register has these bits:

| Bit | Name | Meaning |
|-----|------|---------|
| 0 | run | enables counting |
| 1 | aload | auto-reload |
| 2 | osel | second mode bit |
| 3 | pwm | PWM mode |
| 4 | csel | tick source: 0 = `tick_cpu`, 1 = `tick_osc` |
| 5 | evt | event-counter mode |
| 6 | irqen | interrupt enable |

Top module: `reload_timer`

## Requirements
- R1: After reset the count, the flag, the interrupt output and the PWM output are all 0, and the control, holding and active reload registers are 0.
- R2: With run=1 and evt=0, the count rises by one on each clock edge where the selected tick is high (csel=0 selects `tick_cpu`, csel=1 selects `tick_osc`). The unselected tick has no effect.
- R3: With evt=1, the count rises by one only on the clock edge where `evt_in` is first seen high after being low. Both ticks are ignored, and the period is 256 whatever the PWM and mode bits say.
- R4: Outside PWM mode the period is 256. A step taken when the count is 0xFF is an overflow: it sets the flag and loads the count with the holding value if aload=1, or with 0 if aload=0.
- R5: A write to the reload register (`wr_sel`=1) changes only the holding register. At the next overflow the holding value becomes the active value, and that overflow loads the count from it. The PWM duty in progress keeps using the old active value until that overflow.
- R6: With pwm=1 and evt=0, the period is set by {aload, osel}: 00 gives 256, 01 gives 64, 10 gives 32, 11 gives 16. A step taken at count period−1 is an overflow: it sets the flag and restarts the count at 0.
- R7: In PWM mode only the low 8, 6, 5 or 4 bits of the active reload value take part in the duty compare (periods 256, 64, 32, 16). The upper bits are ignored.
- R8: In PWM mode the PWM output, one clock after the count, is high when the masked count is below the masked active reload value. With pwm=0 or evt=1 it is low.
- R9: The flag is cleared by writing 1 to bit 0 of register 3. Writing 0 there does nothing, and an overflow in the same cycle as a clear leaves the flag set. `irq_o` is high exactly when the flag and irqen are both 1.
- R10: A write to register 2 loads the count with `wr_data` and takes priority over a step or an overflow in the same cycle.
- R11: With run=0 the count holds its value whatever the ticks and the event input do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 control, 1 reload, 2 count, 3 flag clear |
| wr_data | input | 8 | Write data |
| tick_cpu | input | 1 | Step pulse from the CPU-clock prescaler |
| tick_osc | input | 1 | Step pulse from the oscillator prescaler |
| evt_in | input | 1 | External event input, counted on rising edges |
| cnt_o | output | 8 | Current count |
| flag_o | output | 1 | Sticky overflow flag |
| irq_o | output | 1 | Interrupt request |
| pwm_o | output | 1 | PWM output, registered |

## Verification
A register write, a step or an overflow shows up on `cnt_o` and `flag_o` right after the clock edge that samples it. `irq_o` follows the flag in the same cycle. `pwm_o` lags the count by one edge, because the compare result is registered. The bench drives every input one time unit after a rising edge and samples one time unit after the next edge. Count and flag checks therefore fall on the edge that applied the stimulus. PWM duty is measured by counting high samples over sixteen consecutive edges that line up with one period, so the one-edge lag shifts the window but not the total.

// File: rtl/reload_timer_pkg.sv
// Shared types for the double-buffered auto-reload timer.
// Assumes the counter is at least 7 bits wide so the control word fits in one write.
package reload_timer_pkg;

    // Control word; bit 0 is run, bit 6 is interrupt enable.
    typedef struct packed {
        logic irq_en;
        logic evt_mode;
        logic clk_sel;
        logic pwm_en;
        logic out_sel;
        logic aload;
        logic run;
    } ctrl_t;

    // Write-port register selection.
    typedef enum logic [1:0] {
        SEL_CTRL   = 2'd0,
        SEL_RELOAD = 2'd1,
        SEL_COUNT  = 2'd2,
        SEL_FLAG   = 2'd3
    } reg_sel_e;

    // Period choice: full range, or the range shifted down by 2, 3 or 4 bits.
    typedef enum logic [1:0] {
        BND_FULL  = 2'd0,
        BND_DIV4  = 2'd1,
        BND_DIV8  = 2'd2,
        BND_DIV16 = 2'd3
    } bound_e;

    // Picks the period from the control word.
    function automatic bound_e pick_bound(input ctrl_t c);
        if (!c.pwm_en || c.evt_mode) begin
            return BND_FULL;
        end
        case ({c.aload, c.out_sel})
            2'b00:   return BND_FULL;
            2'b01:   return BND_DIV4;
            2'b10:   return BND_DIV8;
            default: return BND_DIV16;
        endcase
    endfunction

endpackage

// File: rtl/rt_regs.sv
// Write-port register file: control word, reload holding buffer, count-load
// strobe and the sticky overflow flag.
// Assumes one write per cycle; an overflow wins over a flag clear in the same cycle.
module rt_regs
    import reload_timer_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             ovf,
    output ctrl_t            ctrl,
    output logic [CNT_W-1:0] hold,
    output logic             cnt_wr,
    output logic [CNT_W-1:0] cnt_wdata,
    output logic             flag
);
    localparam int CTRL_W = $bits(ctrl_t);

    reg_sel_e sel;
    logic     hit_ctrl;
    logic     hit_reload;
    logic     hit_flag;

    // Decode the write target.
    always_comb begin
        sel        = reg_sel_e'(wr_sel);
        hit_ctrl   = wr_en && (sel == SEL_CTRL);
        hit_reload = wr_en && (sel == SEL_RELOAD);
        hit_flag   = wr_en && (sel == SEL_FLAG);
        cnt_wr     = wr_en && (sel == SEL_COUNT);
        cnt_wdata  = wr_data;
    end

    // Control word register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else if (hit_ctrl) begin
            ctrl <= ctrl_t'(wr_data[CTRL_W-1:0]);
        end
    end

    // Reload holding buffer; write-only from software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold <= '0;
        end else if (hit_reload) begin
            hold <= wr_data;
        end
    end

    // Sticky overflow flag, cleared by writing one to bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (ovf) begin
            flag <= 1'b1;
        end else if (hit_flag && wr_data[0]) begin
            flag <= 1'b0;
        end
    end

endmodule

// File: rtl/rt_core.sv
// Counting core: step source selection, event edge detection, period mask,
// overflow detection, count reload and the active reload register.
// Assumes the event input is already synchronous to clk.
module rt_core
    import reload_timer_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ctrl_t            ctrl,
    input  logic [CNT_W-1:0] hold,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic             tick_cpu,
    input  logic             tick_osc,
    input  logic             evt_in,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] active,
    output logic [CNT_W-1:0] mask,
    output logic             step,
    output logic             ovf,
    output logic             pwm_mode,
    output logic             reload_en
);
    localparam logic [CNT_W-1:0] ONES = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    logic             evt_q;
    logic             evt_rise;
    logic             tick_sel;
    bound_e           bnd;
    logic [CNT_W-1:0] cnt_nxt;

    // Remember the last event level for rising-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_q <= 1'b0;
        end else begin
            evt_q <= evt_in;
        end
    end

    // Step source, period mask and overflow condition.
    always_comb begin
        evt_rise  = evt_in && !evt_q;
        tick_sel  = ctrl.clk_sel ? tick_osc : tick_cpu;
        step      = ctrl.run && (ctrl.evt_mode ? evt_rise : tick_sel);
        pwm_mode  = ctrl.pwm_en && !ctrl.evt_mode;
        reload_en = ctrl.aload && !pwm_mode;
        bnd       = pick_bound(ctrl);
        case (bnd)
            BND_FULL: mask = ONES;
            BND_DIV4: mask = ONES >> 2;
            BND_DIV8: mask = ONES >> 3;
            default:  mask = ONES >> 4;
        endcase
        ovf = step && ((cnt & mask) == mask);
    end

    // Next count: a software load first, then overflow, then a plain step.
    always_comb begin
        cnt_nxt = cnt;
        if (cnt_wr) begin
            cnt_nxt = cnt_wdata;
        end else if (ovf) begin
            cnt_nxt = reload_en ? hold : '0;
        end else if (step) begin
            cnt_nxt = cnt + ONE;
        end
    end

    // Count register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else begin
            cnt <= cnt_nxt;
        end
    end

    // Active reload register, loaded from the holding buffer at overflow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= '0;
        end else if (ovf) begin
            active <= hold;
        end
    end

endmodule

// File: rtl/rt_pwm.sv
// PWM/buzzer output stage: compares the masked count with the masked active
// reload value. REG_OUT=1 registers the result for a glitch-free pin.
// Assumes mask has only low-order ones.
module rt_pwm #(
    parameter int CNT_W   = 8,
    parameter bit REG_OUT = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwm_mode,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] active,
    input  logic [CNT_W-1:0] mask,
    output logic             pwm
);
    logic duty_hi;

    // Duty compare over the bits inside the period.
    always_comb begin
        duty_hi = pwm_mode && ((cnt & mask) < (active & mask));
    end

    generate
        if (REG_OUT) begin : g_reg
            logic pwm_q;
            // Register the compare result.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    pwm_q <= 1'b0;
                end else begin
                    pwm_q <= duty_hi;
                end
            end
            assign pwm = pwm_q;
        end else begin : g_comb
            assign pwm = duty_hi;
        end
    endgenerate

endmodule

// File: rtl/reload_timer.sv
// Top level of the double-buffered auto-reload timer/counter.
// Assumes the tick inputs are one-cycle strobes from an external prescaler.
module reload_timer
    import reload_timer_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             tick_cpu,
    input  logic             tick_osc,
    input  logic             evt_in,
    output logic [CNT_W-1:0] cnt_o,
    output logic             flag_o,
    output logic             irq_o,
    output logic             pwm_o
);
    ctrl_t            ctrl;
    logic [CNT_W-1:0] hold;
    logic             cnt_wr;
    logic [CNT_W-1:0] cnt_wdata;
    logic             flag;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] active;
    logic [CNT_W-1:0] mask;
    logic             step;
    logic             ovf;
    logic             pwm_mode;
    logic             reload_en;

    rt_regs #(.CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .ovf       (ovf),
        .ctrl      (ctrl),
        .hold      (hold),
        .cnt_wr    (cnt_wr),
        .cnt_wdata (cnt_wdata),
        .flag      (flag)
    );

    rt_core #(.CNT_W(CNT_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl      (ctrl),
        .hold      (hold),
        .cnt_wr    (cnt_wr),
        .cnt_wdata (cnt_wdata),
        .tick_cpu  (tick_cpu),
        .tick_osc  (tick_osc),
        .evt_in    (evt_in),
        .cnt       (cnt),
        .active    (active),
        .mask      (mask),
        .step      (step),
        .ovf       (ovf),
        .pwm_mode  (pwm_mode),
        .reload_en (reload_en)
    );

    rt_pwm #(.CNT_W(CNT_W), .REG_OUT(1'b1)) u_pwm (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwm_mode (pwm_mode),
        .cnt      (cnt),
        .active   (active),
        .mask     (mask),
        .pwm      (pwm_o)
    );

    // Drive the observable outputs.
    always_comb begin
        cnt_o  = cnt;
        flag_o = flag;
        irq_o  = flag && ctrl.irq_en;
    end

endmodule

// File: rtl/reload_timer_chk.sv
// Assertion checker for reload_timer, attached by bind below.
// Assumes reset is held for at least one clock edge at start-up.
module reload_timer_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             step,
    input logic             ovf,
    input logic             cnt_wr,
    input logic [CNT_W-1:0] cnt_wdata,
    input logic             pwm_mode,
    input logic             reload_en,
    input logic [CNT_W-1:0] cnt,
    input logic             flag,
    input logic             irq,
    input logic             pwm
);
    assert_step_inc_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !ovf && !cnt_wr) |=> (cnt == $past(cnt) + CNT_W'(1)));

    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !cnt_wr) |=> $stable(cnt));

    assert_ovf_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> flag);

    assert_flag_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(ovf));

    assert_wrap_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !cnt_wr && !reload_en) |=> (cnt == '0));

    assert_irq_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> flag);

    assert_pwm_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwm_mode && !$past(pwm_mode)) |-> !pwm);

    assert_cnt_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> (cnt == $past(cnt_wdata)));

endmodule

bind reload_timer reload_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .step      (step),
    .ovf       (ovf),
    .cnt_wr    (cnt_wr),
    .cnt_wdata (cnt_wdata),
    .pwm_mode  (pwm_mode),
    .reload_en (reload_en),
    .cnt       (cnt),
    .flag      (flag_o),
    .irq       (irq_o),
    .pwm       (pwm_o)
);

// File: tb/tb_reload_timer.sv
module tb_reload_timer;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] C_RUN = 8'h01, C_ALD = 8'h02, C_OSEL = 8'h04, C_PWM = 8'h08,
                           C_CSEL = 8'h10, C_EVT = 8'h20, C_IRQ = 8'h40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic       tick_cpu = 1'b0;
    logic       tick_osc = 1'b0;
    logic       evt_in = 1'b0;
    logic [7:0] cnt_o;
    logic       flag_o, irq_o, pwm_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    reload_timer dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .tick_cpu(tick_cpu), .tick_osc(tick_osc), .evt_in(evt_in),
        .cnt_o(cnt_o), .flag_o(flag_o), .irq_o(irq_o), .pwm_o(pwm_o)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [7:0] d);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        cyc(1);
        wr_en = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1", "count", int'(cnt_o), 0);
        chk("R1", "flag", int'(flag_o), 0);
        chk("R1", "irq", int'(irq_o), 0);
        chk("R1", "pwm", int'(pwm_o), 0);
    endtask

    task automatic t_count();
        wr(2'd0, C_RUN);
        wr(2'd2, 8'h10);
        tick_cpu = 1'b1; cyc(3); tick_cpu = 1'b0;
        chk("R2", "cpu ticks", int'(cnt_o), 8'h13);
        tick_osc = 1'b1; cyc(2); tick_osc = 1'b0;
        chk("R2", "unselected tick", int'(cnt_o), 8'h13);
        wr(2'd0, C_RUN | C_CSEL);
        tick_osc = 1'b1; cyc(2); tick_osc = 1'b0;
        chk("R2", "osc ticks", int'(cnt_o), 8'h15);
        wr(2'd0, C_CSEL);
        tick_osc = 1'b1; evt_in = 1'b1; cyc(3); tick_osc = 1'b0; evt_in = 1'b0;
        chk("R11", "stopped", int'(cnt_o), 8'h15);
        cyc(1);
    endtask

    task automatic t_wrap();
        wr(2'd0, C_RUN);
        wr(2'd2, 8'hFE);
        tick_cpu = 1'b1; cyc(1);
        chk("R4", "count before top", int'(cnt_o), 8'hFF);
        chk("R4", "no flag before top", int'(flag_o), 0);
        cyc(1); tick_cpu = 1'b0;
        chk("R4", "wrap to zero", int'(cnt_o), 0);
        chk("R4", "flag at overflow", int'(flag_o), 1);
        chk("R9", "irq masked", int'(irq_o), 0);
        wr(2'd3, 8'h01);
        chk("R9", "flag cleared", int'(flag_o), 0);
    endtask

    task automatic t_reload();
        wr(2'd0, C_RUN | C_ALD);
        wr(2'd1, 8'h64);
        wr(2'd2, 8'hFF);
        tick_cpu = 1'b1; cyc(1); tick_cpu = 1'b0;
        chk("R4", "reload value", int'(cnt_o), 8'h64);
        chk("R4", "reload flag", int'(flag_o), 1);
        wr(2'd1, 8'h80);
        tick_cpu = 1'b1; cyc(1); tick_cpu = 1'b0;
        chk("R5", "holding write leaves count", int'(cnt_o), 8'h65);
        wr(2'd2, 8'hFF);
        tick_cpu = 1'b1; cyc(1); tick_cpu = 1'b0;
        chk("R5", "new reload at overflow", int'(cnt_o), 8'h80);
    endtask

    task automatic t_flag();
        wr(2'd0, C_RUN | C_ALD | C_IRQ);
        chk("R9", "irq with flag", int'(irq_o), 1);
        wr(2'd3, 8'h00);
        chk("R9", "zero write keeps flag", int'(flag_o), 1);
        wr(2'd3, 8'h01);
        chk("R9", "w1c flag", int'(flag_o), 0);
        chk("R9", "irq drops", int'(irq_o), 0);
        wr(2'd2, 8'hFF);
        tick_cpu = 1'b1;
        wr(2'd3, 8'h01);
        tick_cpu = 1'b0;
        chk("R9", "set wins over clear", int'(flag_o), 1);
        chk("R9", "irq on set", int'(irq_o), 1);
        wr(2'd3, 8'h01);
    endtask

    task automatic t_cnt_write();
        tick_cpu = 1'b1;
        wr(2'd2, 8'h40);
        chk("R10", "load beats step", int'(cnt_o), 8'h40);
        cyc(1); tick_cpu = 1'b0;
        chk("R10", "count after load", int'(cnt_o), 8'h41);
    endtask

    task automatic t_event();
        wr(2'd0, C_RUN | C_EVT | C_PWM | C_ALD | C_OSEL);
        wr(2'd2, 8'h0E);
        tick_cpu = 1'b1; tick_osc = 1'b1; cyc(2);
        chk("R3", "ticks ignored", int'(cnt_o), 8'h0E);
        evt_in = 1'b1; cyc(1);
        chk("R3", "first edge", int'(cnt_o), 8'h0F);
        cyc(2);
        chk("R3", "level not counted", int'(cnt_o), 8'h0F);
        evt_in = 1'b0; cyc(1);
        evt_in = 1'b1; cyc(1);
        chk("R3", "second edge past 16", int'(cnt_o), 8'h10);
        chk("R3", "no overflow at 16", int'(flag_o), 0);
        chk("R8", "pwm low in event mode", int'(pwm_o), 0);
        tick_cpu = 1'b0; tick_osc = 1'b0; evt_in = 1'b0;
        cyc(1);
    endtask

    task automatic t_bounds();
        for (int c = 0; c < 4; c++) begin
            int b;
            logic [7:0] cw;
            b = (c == 0) ? 256 : (c == 1) ? 64 : (c == 2) ? 32 : 16;
            cw = C_RUN | C_PWM | ((c & 2) != 0 ? C_ALD : 8'h00) | ((c & 1) != 0 ? C_OSEL : 8'h00);
            wr(2'd0, cw);
            wr(2'd1, 8'h07);
            wr(2'd2, 8'(b - 2));
            tick_cpu = 1'b1; cyc(1);
            chk("R6", $sformatf("top-1 mode %0d", c), int'(cnt_o), b - 1);
            chk("R6", $sformatf("no flag mode %0d", c), int'(flag_o), 0);
            cyc(1); tick_cpu = 1'b0;
            chk("R6", $sformatf("restart mode %0d", c), int'(cnt_o), 0);
            chk("R6", $sformatf("flag mode %0d", c), int'(flag_o), 1);
            wr(2'd3, 8'h01);
        end
    endtask

    task automatic t_pwm();
        int highs;
        wr(2'd0, C_RUN | C_PWM | C_ALD | C_OSEL);
        wr(2'd1, 8'hF5);
        wr(2'd2, 8'h0F);
        tick_cpu = 1'b1; cyc(1);
        chk("R6", "pwm period start", int'(cnt_o), 0);
        highs = 0;
        for (int i = 0; i < 16; i++) begin
            if (i == 4) begin
                wr_en = 1'b1; wr_sel = 2'd1; wr_data = 8'h0A;
            end
            cyc(1);
            wr_en = 1'b0;
            highs += int'(pwm_o);
        end
        chk("R7", "masked duty and old value kept (R5)", highs, 5);
        highs = 0;
        for (int i = 0; i < 16; i++) begin
            cyc(1);
            highs += int'(pwm_o);
        end
        chk("R5", "new duty after overflow (R8)", highs, 10);
        tick_cpu = 1'b0;
        wr(2'd0, C_RUN | C_ALD | C_OSEL);
        cyc(1);
        chk("R8", "pwm low when disabled", int'(pwm_o), 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        t_reset();
        t_count();
        t_wrap();
        t_reload();
        t_flag();
        t_cnt_write();
        t_event();
        t_bounds();
        t_pwm();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

endmodule